// File: doc/BRIEF.md
# Dual-clock FIFO with programmable flags

This block is a first-in first-out buffer whose write port and read port run on unrelated clocks. Words enter on the write clock, are held in a parameterised storage array and leave on the read clock. Five status outputs tell both sides how full the buffer is: full, empty, almost-full, almost-empty and half-full. The full, almost-full and half-full outputs are active low, and so is the empty output (low means no word is available). The almost-full and almost-empty thresholds come from two offset ports that are held stable after reset.

The read side has two modes, chosen by `fwft_i`. In standard mode a read strobe is needed before a word appears on the output. In fall-through mode the head word is moved into an output register by itself, so the output register is one extra storage place. Every threshold therefore moves up by one word in that mode. At build time each of the almost-full and almost-empty flags is set to one of two forms. In the mixed-clock form the flag is asserted by one clock's edge and released by the other's. In the single-clock form it is a register in one domain. Pointers cross between the domains as Gray code through two-flop synchronisers.

Top module: `dcfifo_flags`

## Requirements
- R1: While `rst_ni` is low and after it is released with no traffic, `full_no`=1, `empty_no`=0, `almost_empty_no`=0, `almost_full_no`=1 and `half_full_no`=1.
- R2: In standard mode (`fwft_i`=0), an accepted read strobe puts the oldest stored word on `rdata_o` one read-clock edge later. Words leave in the order they were written, including across the pointer wrap.
- R3: In fall-through mode (`fwft_i`=1), the head word appears on `rdata_o` with no strobe and `empty_no` goes to 1. A strobe sampled on a read-clock edge replaces it with the next word. Without a strobe the word is held.
- R4: `full_no` goes low when the buffer holds D words in standard mode or D+1 words in fall-through mode. A write strobe given while full is dropped, and the word never appears at the output.
- R5: A read strobe given while `empty_no` is low changes nothing. `empty_no` stays low and, in standard mode, `rdata_o` keeps its value.
- R6: `almost_empty_no` is low when the buffer holds at most n words in standard mode, or at most n+1 in fall-through mode, where n is `ae_off_i`.
- R7: `almost_full_no` is low when the buffer holds at least D−m words in standard mode, or at least D+1−m in fall-through mode, where m is `af_off_i`.
- R8: `half_full_no` is low when the buffer holds more than D/2 words in standard mode, or at least D/2+2 in fall-through mode.
- R9: With the mixed-clock almost-full form (`AF_ASYNC`=1, the default), the write-clock edge that reaches the threshold drives `almost_full_no` low at once. The read-clock edge that drops below it drives the flag high at once.
- R10: With the single-clock almost-empty form (`AE_ASYNC`=0, the default), `almost_empty_no` changes only on read-clock edges. After writes it is released only once the write pointer has crossed, so it stays low for at least one read-clock edge after the write that lifts the fill above n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| fwft_i | input | 1 | Read mode: 0 standard, 1 fall-through; held stable after reset |
| af_off_i | input | AW+1 | Almost-full offset m |
| ae_off_i | input | AW+1 | Almost-empty offset n |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DW | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DW | Read data |
| full_no | output | 1 | Low when full |
| empty_no | output | 1 | Low when no word is available |
| almost_full_no | output | 1 | Low when at or above the almost-full threshold |
| almost_empty_no | output | 1 | Low when at or below the almost-empty threshold |
| half_full_no | output | 1 | Low when more than half full |

## Verification
The mixed-clock almost-full and half-full outputs follow the pointers without a register, so they are due right after the edge that moves a pointer. The bench samples them half a clock later to test R9. Standard-mode data is due one read-clock edge after the strobe. Full, empty, the single-clock almost-empty flag and the fall-through prefetch wait on two synchroniser stages plus one register, up to about four cycles of the other clock. Every level check in the vector walk therefore comes after ten quiet write-clock cycles, and R10 samples half a cycle after a write to see that lag directly.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  typedef enum logic {RD_STD = 1'b0, RD_FWFT = 1'b1} rd_mode_e;

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
  import dcfifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        wclk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [AW:0] rgray_sync_i,
  input  logic [AW:0] af_thr_i,
  output logic        we_o,
  output logic [AW:0] wbin_o,
  output logic [AW:0] wgray_o,
  output logic        full_o,
  output logic        af_sync_no
);
  localparam int PW = AW + 1;

  logic [AW:0] wbin_q, wgray_q, wbin_n, rbin_s;

  assign rbin_s = PW'(gray2bin(32'(rgray_sync_i)));
  assign full_o = (wgray_q == {~rgray_sync_i[AW:AW-1], rgray_sync_i[AW-2:0]});
  assign we_o   = wr_en_i && !full_o;
  assign wbin_n = wbin_q + {{AW{1'b0}}, we_o};

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q     <= '0;
      wgray_q    <= '0;
      af_sync_no <= 1'b1;
    end else begin
      wbin_q     <= wbin_n;
      wgray_q    <= wbin_n ^ (wbin_n >> 1);
      // judged against the last synced read pointer: late to clear, never late to set
      af_sync_no <= !((wbin_n - rbin_s) >= af_thr_i);
    end
  end

  assign wbin_o  = wbin_q;
  assign wgray_o = wgray_q;

  // R4
  no_overflow_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> $stable(wbin_q));

  // R2
  wgray_step_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);

  // R7
  full_af_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |-> !af_sync_no);
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          rd_en_i,
  input  logic [AW:0]   wgray_sync_i,
  input  logic [AW:0]   ae_off_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW:0]   rbin_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          empty_no,
  output logic          ae_sync_no
);
  localparam int PW = AW + 1;

  rd_mode_e      mode;
  logic [AW:0]   rbin_q, rgray_q, rbin_n, wbin_s;
  logic          ram_empty, mem_rd, ov_q;
  logic [DW-1:0] dout_q;

  assign mode      = rd_mode_e'(fwft_i);
  assign wbin_s    = PW'(gray2bin(32'(wgray_sync_i)));
  assign ram_empty = (rgray_q == wgray_sync_i);

  always_comb begin
    case (mode)
      RD_FWFT: mem_rd = !ram_empty && (!ov_q || rd_en_i);
      default: mem_rd = rd_en_i && !ram_empty;
    endcase
  end

  assign rbin_n = rbin_q + {{AW{1'b0}}, mem_rd};

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q     <= '0;
      rgray_q    <= '0;
      ov_q       <= 1'b0;
      dout_q     <= '0;
      ae_sync_no <= 1'b0;
    end else begin
      rbin_q     <= rbin_n;
      rgray_q    <= rbin_n ^ (rbin_n >> 1);
      if (mem_rd) dout_q <= mem_rdata_i;
      ov_q       <= (mode == RD_FWFT) && (mem_rd || (ov_q && !rd_en_i));
      ae_sync_no <= !((wbin_s - rbin_n) <= ae_off_i);
    end
  end

  assign rbin_o   = rbin_q;
  assign rgray_o  = rgray_q;
  assign rdata_o  = dout_q;
  assign empty_no = (mode == RD_FWFT) ? ov_q : !ram_empty;

  // R5
  no_underflow_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ram_empty |=> $stable(rbin_q));

  // R3
  fwft_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (mode == RD_FWFT && ov_q && !rd_en_i) |=> (ov_q && $stable(dout_q)));

  // R6
  empty_ae_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ram_empty |-> !ae_sync_no);

  // R2
  rgray_step_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
  parameter int DW       = 18,
  parameter int AW       = 4,
  parameter bit AF_ASYNC = 1'b1,
  parameter bit AE_ASYNC = 1'b0
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic [AW:0]   af_off_i,
  input  logic [AW:0]   ae_off_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_no,
  output logic          empty_no,
  output logic          almost_full_no,
  output logic          almost_empty_no,
  output logic          half_full_no
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [AW:0]   wbin, wgray, rbin, rgray, rgray_w, wgray_r, af_thr, fill_x;
  logic          we, full, af_sync_no, ae_sync_no;
  logic [DW-1:0] mem_rdata;

  assign af_thr = PW'(DEPTH) - af_off_i;

  dcfifo_sync #(.W(PW)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_w)
  );

  dcfifo_sync #(.W(PW)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_r)
  );

  dcfifo_wr_ctl #(.AW(AW)) u_wr (
    .wclk_i(wclk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .rgray_sync_i(rgray_w), .af_thr_i(af_thr), .we_o(we),
    .wbin_o(wbin), .wgray_o(wgray), .full_o(full), .af_sync_no(af_sync_no)
  );

  dcfifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(wbin[AW-1:0]), .wdata_i(wdata_i),
    .raddr_i(rbin[AW-1:0]), .rdata_o(mem_rdata)
  );

  dcfifo_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
    .rclk_i(rclk_i), .rst_ni(rst_ni), .fwft_i(fwft_i), .rd_en_i(rd_en_i),
    .wgray_sync_i(wgray_r), .ae_off_i(ae_off_i), .mem_rdata_i(mem_rdata),
    .rbin_o(rbin), .rgray_o(rgray), .rdata_o(rdata_o),
    .empty_no(empty_no), .ae_sync_no(ae_sync_no)
  );

  // stored-word count from both live pointers; moves on either clock's edge
  assign fill_x       = wbin - rbin;
  assign full_no      = !full;
  assign half_full_no = !(fill_x > PW'(DEPTH / 2));

  generate
    if (AF_ASYNC) begin : g_af_mixed
      logic af_unused;
      assign af_unused      = af_sync_no;
      assign almost_full_no = !(fill_x >= af_thr);
    end else begin : g_af_single
      assign almost_full_no = af_sync_no;
    end

    if (AE_ASYNC) begin : g_ae_mixed
      logic ae_unused;
      assign ae_unused       = ae_sync_no;
      assign almost_empty_no = !(fill_x <= ae_off_i);
    end else begin : g_ae_single
      assign almost_empty_no = ae_sync_no;
    end
  endgenerate
endmodule

// File: tb/dcfifo_flags_bench.sv
module dcfifo_flags_bench;
  localparam int DW    = 18;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic [7:0] nw;
    logic [7:0] nr;
  } step_t;

  localparam int NSTEP = 22;
  localparam step_t TAB [NSTEP] = '{
    '{8'd2, 8'd0}, '{8'd1, 8'd0}, '{8'd5, 8'd0}, '{8'd1, 8'd0},
    '{8'd3, 8'd0}, '{8'd1, 8'd0}, '{8'd3, 8'd0}, '{8'd1, 8'd0},
    '{8'd1, 8'd0}, '{8'd0, 8'd1}, '{8'd0, 8'd4}, '{8'd0, 8'd3},
    '{8'd0, 8'd1}, '{8'd0, 8'd5}, '{8'd0, 8'd1}, '{8'd0, 8'd1},
    '{8'd0, 8'd2}, '{8'd0, 8'd1}, '{8'd1, 8'd0}, '{8'd0, 8'd1},
    '{8'd2, 8'd0}, '{8'd0, 8'd2}
  };

  logic          wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0, fwft = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [AW:0]   af_off = 5'd3, ae_off = 5'd2;
  logic [DW-1:0] rdata;
  logic          full_no, empty_no, almost_full_no, almost_empty_no, half_full_no;

  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;
  logic [DW-1:0] mq [$];
  logic [DW-1:0] seq = 18'd1;

  always #2 wclk = ~wclk;
  initial begin
    #1;
    forever #2 rclk = ~rclk;
  end

  dcfifo_flags #(.DW(DW), .AW(AW)) u_dcfifo_flags (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .fwft_i(fwft),
    .af_off_i(af_off), .ae_off_i(ae_off), .wr_en_i(wr_en), .wdata_i(wdata),
    .rd_en_i(rd_en), .rdata_o(rdata), .full_no(full_no), .empty_no(empty_no),
    .almost_full_no(almost_full_no), .almost_empty_no(almost_empty_no),
    .half_full_no(half_full_no)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // words counted by the pointers: the fall-through output register is not among them
  function automatic int pfill();
    int t = mq.size();
    if (fwft && t > 0) return t - 1;
    return t;
  endfunction

  task automatic check_flags(input string where);
    int p = pfill();
    chk($sformatf("R4 full %s", where), full_no, (p != DEPTH));
    chk($sformatf("R7 almost-full %s", where), almost_full_no, !(p >= DEPTH - 3));
    chk($sformatf("R8 half-full %s", where), half_full_no, !(p > DEPTH / 2));
    chk($sformatf("R6 almost-empty %s", where), almost_empty_no, !(p <= 2));
    chk($sformatf("R5 empty %s", where), empty_no, (mq.size() != 0));
  endtask

  task automatic settle();
    repeat (10) @(negedge wclk);
  endtask

  task automatic check_reset_state(input string where);
    chk($sformatf("R1 full %s", where), full_no, 1);
    chk($sformatf("R1 empty %s", where), empty_no, 0);
    chk($sformatf("R1 almost-empty %s", where), almost_empty_no, 0);
    chk($sformatf("R1 almost-full %s", where), almost_full_no, 1);
    chk($sformatf("R1 half-full %s", where), half_full_no, 1);
  endtask

  task automatic do_reset(input bit mode);
    rst_ni = 1'b0;
    fwft   = mode;
    wr_en  = 1'b0;
    rd_en  = 1'b0;
    repeat (3) @(negedge wclk);
    mq.delete();
    check_reset_state("during reset");
    rst_ni = 1'b1;
    settle();
    check_reset_state("after release");
  endtask

  task automatic do_write();
    int cap = fwft ? DEPTH + 1 : DEPTH;
    @(negedge wclk);
    wr_en = 1'b1;
    wdata = seq;
    @(negedge wclk);
    wr_en = 1'b0;
    if (mq.size() < cap) mq.push_back(seq);
    seq++;
  endtask

  task automatic do_read();
    logic [DW-1:0] prev;
    logic [DW-1:0] exp;
    if (!fwft) begin
      @(negedge rclk);
      prev  = rdata;
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
      if (mq.size() > 0) begin
        exp = mq.pop_front();
        chk("R2 standard read data", rdata, exp);
      end else begin
        chk("R5 read while empty keeps data", rdata, prev);
      end
    end else begin
      @(negedge rclk);
      if (mq.size() > 0) chk("R3 fall-through head word", rdata, mq[0]);
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
      if (mq.size() > 0) void'(mq.pop_front());
      else chk("R5 read while empty keeps empty", empty_no, 0);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // vector walk in both read modes
    for (int mode = 0; mode < 2; mode++) begin
      do_reset(mode[0]);
      for (int s = 0; s < NSTEP; s++) begin
        repeat (int'(TAB[s].nw)) do_write();
        repeat (int'(TAB[s].nr)) do_read();
        settle();
        check_flags($sformatf("mode %0d step %0d", mode, s));
      end
    end

    // R9: mixed-clock almost-full reacts on the edge itself
    do_reset(1'b0);
    repeat (12) do_write();
    settle();
    chk("R7 below threshold", almost_full_no, 1);
    do_write();
    chk("R9 set on write edge", almost_full_no, 0);
    do_read();
    chk("R9 cleared on read edge", almost_full_no, 1);

    // R10: single-clock almost-empty lags a write
    do_reset(1'b0);
    repeat (2) do_write();
    settle();
    chk("R6 at n words", almost_empty_no, 0);
    do_write();
    chk("R10 held until read domain sees write", almost_empty_no, 0);
    settle();
    chk("R10 released on read clock", almost_empty_no, 1);

    // R1: reset in mid-traffic, then fall-through with no strobe
    repeat (5) do_write();
    settle();
    do_reset(1'b1);
    do_write();
    settle();
    chk("R3 first word falls through", empty_no, 1);
    chk("R3 first word value", rdata, mq[0]);
    repeat (4) @(negedge rclk);
    chk("R3 word held without strobe", rdata, mq[0]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule